// File: doc/BRIEF.md
# Signed Halve/Double Unit

This block takes a signed (two's-complement) operand and a two-bit operation code. Depending on the code, it passes the operand through unchanged, doubles it with a one-place left shift, or halves it with a one-place arithmetic right shift. The remaining code drives an all-zero result.

Alongside the result, the unit raises an inexact flag whenever the arithmetic answer cannot be represented exactly in the operand width. For doubling, this happens when the true product falls outside the signed range. For halving, it happens when the operand is odd, so that the fractional half is lost.

The unit is purely combinational. Each result bit comes from its own four-way bit selector, and a small separate detector produces the flag. The operand width is a parameter with a default of 8. It is meant to sit inside a larger datapath that needs a cheap scale-by-two step with a check that the scaling is exact.

Top module: `shb_unit`

## Requirements
- R1: With op code 2'b00 (keep), result equals the operand and the inexact flag is 0.
- R2: With op code 2'b10 (double), result bit i equals operand bit i-1 for i >= 1, and result bit 0 is 0.
- R3: With op code 2'b10, the inexact flag is 1 exactly when the two most significant operand bits differ, which is when the product lies outside -2^(W-1) to 2^(W-1)-1 (for W=8, -128 to 127).
- R4: With op code 2'b11 (halve), result bit i equals operand bit i+1 for i < W-1, and the top result bit repeats the operand's sign bit. For W=8, the result equals the floor of the signed operand divided by two.
- R5: With op code 2'b11, the inexact flag equals operand bit 0, so it is set for an odd operand.
- R6: With op code 2'b01 (unused), result is all zeros and the inexact flag is 0.
- R7: For W=8 the unit gives the following worked cases:
  - 8'b11000100 (-60) doubled gives 8'b10001000 (-120) with flag 0.
  - 8'b00110001 (49) doubled gives 8'b01100010 (98) with flag 0.
  - 8'b10100000 (-96) doubled gives flag 1.
- R8: The outputs are a pure function of the present inputs. A change on operand or op code shows up on the outputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | W (8) | Signed two's-complement operand |
| op_i | input | 2 | Operation code: 00 keep, 01 zero, 10 double, 11 halve |
| result_o | output | W (8) | Scaled result |
| inexact_o | output | 1 | Result is not the exact arithmetic answer |

## Verification
The result and the inexact flag are produced by separate logic but must agree in the same evaluation. The two cases that test this are an overflowing doubling, where the result must still show the wrapped shifted pattern while the flag rises, and an odd halving, where the result must show the floored half while the flag rises. The bench provokes both by sweeping every operand under every op code. It judges result and flag together against signed integer arithmetic: range overflow for doubling, and a nonzero remainder for halving. Directed cases at the range edges (63, 64, -64, -65, -1, -128, 127) pin the boundaries of both conditions.

// File: rtl/shb_pkg.sv
package shb_pkg;

    typedef enum logic [1:0] {
        OP_KEEP = 2'b00,
        OP_ZERO = 2'b01,
        OP_DBL  = 2'b10,
        OP_HALF = 2'b11
    } shb_op_e;

    // Four candidate sources for one result bit.
    typedef struct packed {
        logic keep;
        logic from_lower;
        logic from_upper;
    } shb_bit_src_t;

endpackage

// File: rtl/shb_bit_sel.sv
module shb_bit_sel
    import shb_pkg::*;
(
    input  shb_bit_src_t src_i,
    input  logic [1:0]   op_i,
    output logic         bit_o
);
    logic bit_d;

    always_comb begin
        unique case (shb_op_e'(op_i))
            OP_KEEP: bit_d = src_i.keep;
            OP_ZERO: bit_d = 1'b0;
            OP_DBL:  bit_d = src_i.from_lower;
            OP_HALF: bit_d = src_i.from_upper;
            default: bit_d = 1'b0;
        endcase
    end

    assign bit_o = bit_d;
endmodule

// File: rtl/shb_err_det.sv
module shb_err_det
    import shb_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] operand_i,
    input  logic [1:0]   op_i,
    output logic         inexact_o
);
    localparam int MSB = W - 1;

    logic sign_flip_d;
    logic odd_d;
    logic inexact_d;

    always_comb begin
        // Doubling leaves the range when the sign would be replaced by a differing bit.
        sign_flip_d = operand_i[MSB] ^ operand_i[MSB-1];
        // Halving drops bit 0.
        odd_d       = operand_i[0];
        unique case (shb_op_e'(op_i))
            OP_DBL:  inexact_d = sign_flip_d;
            OP_HALF: inexact_d = odd_d;
            default: inexact_d = 1'b0;
        endcase
    end

    assign inexact_o = inexact_d;
endmodule

// File: rtl/shb_unit.sv
module shb_unit
    import shb_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] operand_i,
    input  logic [1:0]   op_i,
    output logic [W-1:0] result_o,
    output logic         inexact_o
);
    localparam int MSB = W - 1;

    shb_bit_src_t src_d [W];
    logic [W-1:0] result_d;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_low
            assign src_d[i].from_lower = 1'b0;
        end else begin : g_mid_lo
            assign src_d[i].from_lower = operand_i[i-1];
        end

        if (i == MSB) begin : g_top
            assign src_d[i].from_upper = operand_i[MSB];
        end else begin : g_mid_hi
            assign src_d[i].from_upper = operand_i[i+1];
        end

        assign src_d[i].keep = operand_i[i];

        shb_bit_sel u_sel (
            .src_i (src_d[i]),
            .op_i  (op_i),
            .bit_o (result_d[i])
        );
    end

    shb_err_det #(.W(W)) u_err (
        .operand_i (operand_i),
        .op_i      (op_i),
        .inexact_o (inexact_o)
    );

    assign result_o = result_d;
endmodule

// File: rtl/shb_unit_chk.sv
module shb_unit_chk #(
    parameter int W = 8
) (
    input logic [W-1:0] operand_i,
    input logic [1:0]   op_i,
    input logic [W-1:0] result_o,
    input logic         inexact_o
);
    always_comb begin
        if (op_i == 2'b00) begin
            assert_keep_R1: assert (result_o == operand_i && !inexact_o)
                else $error("keep mismatch");
        end
        if (op_i == 2'b01) begin
            assert_zero_R6: assert (result_o == '0 && !inexact_o)
                else $error("zero code mismatch");
        end
        if (op_i == 2'b10) begin
            assert_dbl_R2: assert (result_o[0] == 1'b0 && result_o[W-1:1] == operand_i[W-2:0])
                else $error("double mismatch");
            assert_no_overflow_R3: assert (inexact_o == (result_o[W-1] != operand_i[W-1]))
                else $error("double flag mismatch");
        end
        if (op_i == 2'b11) begin
            assert_half_R4: assert (result_o[W-1] == operand_i[W-1] && result_o[W-2:0] == operand_i[W-1:1])
                else $error("halve mismatch");
            assert_odd_R5: assert (inexact_o == operand_i[0])
                else $error("halve flag mismatch");
        end
    end
endmodule

bind shb_unit shb_unit_chk #(.W(W)) u_chk (
    .operand_i (operand_i),
    .op_i      (op_i),
    .result_o  (result_o),
    .inexact_o (inexact_o)
);

// File: tb/shb_unit_tb_top.sv
`timescale 1ns/1ps
module shb_unit_tb_top;
    localparam int W = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic [W-1:0] operand;
    logic [1:0]   op;
    logic [W-1:0] result;
    logic         inexact;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    shb_unit #(.W(W)) dut_i (
        .operand_i (operand),
        .op_i      (op),
        .result_o  (result),
        .inexact_o (inexact)
    );

    // {operand, op, expected result, expected flag}
    typedef struct packed {
        logic [7:0] d;
        logic [1:0] s;
        logic [7:0] y;
        logic       e;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{8'b11000100, 2'b10, 8'b10001000, 1'b0},  // R7 -60 -> -120
        '{8'b00110001, 2'b10, 8'b01100010, 1'b0},  // R7 49 -> 98
        '{8'b10100000, 2'b10, 8'b01000000, 1'b1},  // R7 -96 overflows
        '{8'd63,       2'b10, 8'd126,      1'b0},  // R3 edge ok
        '{8'd64,       2'b10, 8'd128,      1'b1},  // R3 positive overflow
        '{8'hC0,       2'b10, 8'h80,       1'b0},  // R3 -64 -> -128 ok
        '{8'hBF,       2'b10, 8'h7E,       1'b1},  // R3 -65 overflows
        '{8'hFF,       2'b11, 8'hFF,       1'b1},  // R4 -1 halves to -1, odd
        '{8'h80,       2'b11, 8'hC0,       1'b0},  // R4 -128 -> -64
        '{8'h7F,       2'b11, 8'h3F,       1'b1},  // R5 127 odd
        '{8'hFB,       2'b11, 8'hFD,       1'b1},  // R4 -5 -> -3 floor
        '{8'h5A,       2'b00, 8'h5A,       1'b0},  // R1 keep
        '{8'hFF,       2'b01, 8'h00,       1'b0},  // R6 zero code
        '{8'h81,       2'b00, 8'h81,       1'b0}   // R1 keep negative odd
    };

    task automatic check(input logic [7:0] d, input logic [1:0] s,
                         input logic [7:0] ey, input logic ee, input string req);
        operand = d;
        op      = s;
        #1;
        n_vec++;
        if (result !== ey || inexact !== ee) begin
            n_fail++;
            $display("FAIL %s: d=%b s=%b got y=%b e=%b expected y=%b e=%b",
                     req, d, s, result, inexact, ey, ee);
        end
    endtask

    function automatic logic [8:0] model(input logic [7:0] d, input logic [1:0] s);
        int v;
        int r;
        logic e;
        v = int'($signed(d));
        case (s)
            2'b00: begin r = v; e = 1'b0; end
            2'b10: begin r = v * 2; e = (r > 127) || (r < -128); end
            2'b11: begin r = (v - (v & 1)) / 2; e = (v & 1) != 0; end
            default: begin r = 0; e = 1'b0; end
        endcase
        return {e, 8'(r)};
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: expired, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [8:0] m;
        operand = '0;
        op      = 2'b00;
        @(negedge clk);
        // Initial state: zero operand in keep mode (R1)
        check(8'h00, 2'b00, 8'h00, 1'b0, "R1");

        for (int k = 0; k < NV; k++) begin
            check(VEC[k].d, VEC[k].s, VEC[k].y, VEC[k].e, "R7/table");
        end

        // Full sweep against signed arithmetic (R1 R2 R3 R4 R5 R6)
        for (int s = 0; s < 4; s++) begin
            for (int d = 0; d < 256; d++) begin
                m = model(8'(d), 2'(s));
                check(8'(d), 2'(s), m[7:0], m[8], "R1-sweep R2 R3 R4 R5 R6");
            end
        end

        // R8: change inputs with no clock edge between and see outputs follow
        @(negedge clk);
        check(8'h21, 2'b10, 8'h42, 1'b0, "R8");
        check(8'h21, 2'b11, 8'h10, 1'b1, "R8");
        check(8'h40, 2'b11, 8'h20, 1'b0, "R8");
        check(8'h40, 2'b01, 8'h00, 1'b0, "R6");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule